// File: doc/BRIEF.md
# Transmit Message-Object Scheduler

This block sits on the transmit side of a bus controller and arbitrates a bank of message objects, each a slot that holds a ready frame. Each object has one enable bit. Software sets enable bits through one write-one mask and clears them through a second write-one mask, so several objects can change in one write. When the bus is idle and the scheduler has nothing in flight, it offers the lowest-numbered eligible object to a frame transmitter. That offer carries the object index and the object's byte count.

The transmitter accepts the offer and later reports success or error with a one-cycle pulse. On success, the object's enable bit is dropped and its transmit-OK bit is set. On error, a sticky error flag is raised and the object stays enabled. The next choice again goes to the lowest-numbered eligible object, so a retry can be overtaken by a lower object that was enabled in the meantime. Software acknowledges transmit-OK bits and the error flag with write-one-to-clear inputs. A single interrupt line is high while any of these flags is set.

The offer uses valid/ready. Once valid is high, it stays high with a stable index until ready is seen, and the offer is never withdrawn. The transmitter may hold ready low for any number of cycles. Configuration inputs (direction and byte count) must stay stable while an object is enabled.

Top module: `mob_tx_sched`

## Requirements
- R1: A 1 in bit i of `en_set_mask` enables object i at the next clock edge. Bits that are 0 leave their enables unchanged, and any number of bits may be set in one cycle.
- R2: A 1 in bit i of `en_clr_mask` disables object i at the next edge. When set and clear hit the same bit in the same cycle, the clear wins.
- R3: An object is eligible only when its enable is 1, its `cfg_dir` bit is 1 (transmit) and its 4-bit count in `cfg_dlc[4i+3:4i]` is at most 8. An ineligible object is never offered, and its enable bit is left untouched.
- R4: A new offer is made only from the idle scheduler state in a cycle where `bus_idle` is 1. `tx_req_valid` rises one cycle after that edge.
- R5: Among eligible objects, the one with the lowest index is offered.
- R6: While `tx_req_valid` is 1 and `tx_req_ready` is 0, the valid, `tx_req_idx` and `tx_req_dlc` outputs hold. `tx_req_dlc` is the count field of the offered object.
- R7: A `tx_done` pulse on an accepted frame clears that object's enable bit and sets its bit in `txok_vec` at the same edge.
- R8: A `tx_err` pulse on an accepted frame sets `err_flag` and leaves the object enabled, so it is offered again under the R5 rule.
- R9: A 1 in bit i of `ok_ack_mask` clears `txok_vec[i]`, and `err_ack` clears `err_flag`. A hardware set in the same cycle takes priority over the acknowledge.
- R10: `tx_busy` is 1 from the edge that accepts an offer until the edge that takes its result. `tx_done` and `tx_err` are ignored while nothing is accepted.
- R11: `irq` equals the OR of all `txok_vec` bits and `err_flag`.
- R12: After reset, all enables, transmit-OK bits, `err_flag`, `tx_req_valid`, `tx_busy` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_set_mask | input | N_OBJ | Write-one enable set |
| en_clr_mask | input | N_OBJ | Write-one enable clear |
| ok_ack_mask | input | N_OBJ | Write-one transmit-OK acknowledge |
| err_ack | input | 1 | Error flag acknowledge |
| cfg_dir | input | N_OBJ | Per-object direction, 1 = transmit |
| cfg_dlc | input | N_OBJ*4 | Per-object byte count, 4 bits each |
| bus_idle | input | 1 | Bus currently idle |
| tx_req_valid | output | 1 | Offer valid |
| tx_req_ready | input | 1 | Transmitter accepts offer |
| tx_req_idx | output | IDX_W | Offered object index |
| tx_req_dlc | output | 4 | Offered object byte count |
| tx_done | input | 1 | Frame sent successfully (pulse) |
| tx_err | input | 1 | Frame failed (pulse) |
| en_vec | output | N_OBJ | Enable bits |
| txok_vec | output | N_OBJ | Transmit-OK bits |
| err_flag | output | 1 | Sticky transmit error flag |
| tx_busy | output | 1 | A frame is being sent |
| irq | output | 1 | Interrupt request |

## Verification
Three enable patterns are used to test selection order.
- A sparse set of three objects all succeeding checks ascending order.
- A mix in which one object has receive direction and another has an oversized count shows that only truly eligible objects are offered.
- An error on a high object, while a lower one is enabled during its attempt, shows that a retry yields to the lower index.

Acknowledge pulses are coincident with completions, and a done pulse with nothing in flight, to separate set-wins priority and ignore behaviour from plain clearing. A period with the bus busy confirms that no offer appears.

// File: rtl/mob_sched_pkg.sv
package mob_sched_pkg;
  typedef enum logic [1:0] {
    SCH_IDLE  = 2'd0,
    SCH_OFFER = 2'd1,
    SCH_WAIT  = 2'd2
  } sch_state_e;

  localparam int unsigned CNT_W     = 4;
  localparam int unsigned MAX_BYTES = 8;
endpackage

// File: rtl/mob_lowest_pick.sv
module mob_lowest_pick #(
  parameter int unsigned N_OBJ = 8,
  localparam int unsigned IDX_W = $clog2(N_OBJ)
) (
  input  logic [N_OBJ-1:0] cand,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N_OBJ - 1; i >= 0; i--) begin
      if (cand[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/mob_en_bank.sv
module mob_en_bank #(
  parameter int unsigned N_OBJ = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_OBJ-1:0] set_mask,
  input  logic [N_OBJ-1:0] clr_mask,
  input  logic [N_OBJ-1:0] hw_clr,
  output logic [N_OBJ-1:0] en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en <= '0;
    else        en <= (en | set_mask) & ~clr_mask & ~hw_clr;
  end

  // R7: completion clears at most one object
  p_hw_clr_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hw_clr));

  // R1: an uncontested set lands
  p_set_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((en & $past(set_mask & ~clr_mask & ~hw_clr)) ==
              $past(set_mask & ~clr_mask & ~hw_clr)));

  // R2: a clear always wins
  p_clr_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((en & $past(clr_mask)) == '0));
endmodule

// File: rtl/mob_status_bank.sv
module mob_status_bank #(
  parameter int unsigned N_OBJ = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_OBJ-1:0] hw_set,
  input  logic [N_OBJ-1:0] ack_mask,
  input  logic             err_set,
  input  logic             err_ack,
  output logic [N_OBJ-1:0] txok,
  output logic             err_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txok     <= '0;
      err_flag <= 1'b0;
    end else begin
      txok     <= (txok & ~ack_mask) | hw_set;
      err_flag <= (err_flag & ~err_ack) | err_set;
    end
  end

  // R9: hardware set beats a same-cycle acknowledge
  p_set_beats_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((txok & $past(hw_set)) == $past(hw_set)));

  // R8: an error raises the sticky flag
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> err_flag);
endmodule

// File: rtl/mob_tx_sched.sv
module mob_tx_sched
  import mob_sched_pkg::*;
#(
  parameter int unsigned N_OBJ = 8,
  localparam int unsigned IDX_W = $clog2(N_OBJ),
  localparam int unsigned DW    = CNT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_OBJ-1:0]    en_set_mask,
  input  logic [N_OBJ-1:0]    en_clr_mask,
  input  logic [N_OBJ-1:0]    ok_ack_mask,
  input  logic                err_ack,
  input  logic [N_OBJ-1:0]    cfg_dir,
  input  logic [N_OBJ*DW-1:0] cfg_dlc,
  input  logic                bus_idle,
  output logic                tx_req_valid,
  input  logic                tx_req_ready,
  output logic [IDX_W-1:0]    tx_req_idx,
  output logic [DW-1:0]       tx_req_dlc,
  input  logic                tx_done,
  input  logic                tx_err,
  output logic [N_OBJ-1:0]    en_vec,
  output logic [N_OBJ-1:0]    txok_vec,
  output logic                err_flag,
  output logic                tx_busy,
  output logic                irq
);
  sch_state_e       state;
  logic [IDX_W-1:0] sel;
  logic [N_OBJ-1:0] cand;
  logic             pick_any;
  logic [IDX_W-1:0] pick_idx;
  logic             hw_done, hw_err;
  logic [N_OBJ-1:0] done_vec;

  for (genvar g = 0; g < N_OBJ; g++) begin : g_elig
    assign cand[g] = en_vec[g] & cfg_dir[g] &
                     (cfg_dlc[g*DW +: DW] <= DW'(MAX_BYTES));
  end

  mob_lowest_pick #(.N_OBJ(N_OBJ)) u_pick (
    .cand (cand),
    .any  (pick_any),
    .idx  (pick_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SCH_IDLE;
      sel   <= '0;
    end else begin
      unique case (state)
        SCH_IDLE: if (bus_idle && pick_any) begin
          sel   <= pick_idx;
          state <= SCH_OFFER;
        end
        SCH_OFFER: if (tx_req_ready) state <= SCH_WAIT;
        SCH_WAIT:  if (tx_done || tx_err) state <= SCH_IDLE;
        default:   state <= SCH_IDLE;
      endcase
    end
  end

  assign hw_done  = (state == SCH_WAIT) && tx_done;
  assign hw_err   = (state == SCH_WAIT) && tx_err && !tx_done;
  assign done_vec = hw_done ? (N_OBJ'(1) << sel) : '0;

  mob_en_bank #(.N_OBJ(N_OBJ)) u_en (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_mask (en_set_mask),
    .clr_mask (en_clr_mask),
    .hw_clr   (done_vec),
    .en       (en_vec)
  );

  mob_status_bank #(.N_OBJ(N_OBJ)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .hw_set   (done_vec),
    .ack_mask (ok_ack_mask),
    .err_set  (hw_err),
    .err_ack  (err_ack),
    .txok     (txok_vec),
    .err_flag (err_flag)
  );

  assign tx_req_valid = (state == SCH_OFFER);
  assign tx_req_idx   = sel;
  assign tx_req_dlc   = cfg_dlc[sel*DW +: DW];
  assign tx_busy      = (state == SCH_WAIT);
  assign irq          = (|txok_vec) | err_flag;

  // R6: offer holds until accepted
  p_offer_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req_valid && !tx_req_ready) |=> (tx_req_valid && $stable(tx_req_idx)));

  // R4: an offer only follows an idle bus
  p_offer_idle_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_req_valid) |-> $past(bus_idle));

  // R3: offered object was eligible
  p_offer_eligible_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_req_valid) |-> |($past(cand) & (N_OBJ'(1) << tx_req_idx)));

  // R5: no lower eligible object existed
  p_offer_lowest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_req_valid) |->
      (($past(cand) & ((N_OBJ'(1) << tx_req_idx) - N_OBJ'(1))) == '0));

  // R10: busy and offer never overlap
  p_busy_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |-> !tx_req_valid);

  // R7: success retires the object
  p_done_retires_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && tx_done) |=>
      (txok_vec[$past(sel)] && !en_vec[$past(sel)] && !tx_busy));
endmodule

// File: tb/test_mob_tx_sched.sv
module test_mob_tx_sched;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int IW = $clog2(N);

  typedef struct {
    int idx;
    bit err;
    bit ack_same;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] en_set_mask = '0, en_clr_mask = '0, drv_ack = '0, mon_ack = '0;
  logic err_ack = 1'b0;
  logic [N-1:0] cfg_dir;
  logic [N*4-1:0] cfg_dlc;
  logic bus_idle = 1'b0;
  logic tx_req_valid, tx_req_ready;
  logic [IW-1:0] tx_req_idx;
  logic [3:0] tx_req_dlc;
  logic mon_ready = 1'b0, mon_done = 1'b0, mon_err = 1'b0, drv_done = 1'b0;
  logic tx_done, tx_err;
  logic [N-1:0] en_vec, txok_vec, ok_ack_mask;
  logic err_flag, tx_busy, irq;

  bit [3:0] dlc_cfg [N];
  bit mon_active = 1'b0;
  exp_t q[$];
  int n_chk = 0, n_fail = 0;

  assign tx_req_ready = mon_ready;
  assign tx_done = mon_done | drv_done;
  assign tx_err = mon_err;
  assign ok_ack_mask = mon_ack | drv_ack;
  always_comb for (int i = 0; i < N; i++) cfg_dlc[i*4 +: 4] = dlc_cfg[i];

  always #(CLK_PERIOD/2) clk = ~clk;

  mob_tx_sched #(.N_OBJ(N)) i_mob_tx_sched (
    .clk(clk), .rst_n(rst_n), .en_set_mask(en_set_mask), .en_clr_mask(en_clr_mask),
    .ok_ack_mask(ok_ack_mask), .err_ack(err_ack), .cfg_dir(cfg_dir), .cfg_dlc(cfg_dlc),
    .bus_idle(bus_idle), .tx_req_valid(tx_req_valid), .tx_req_ready(tx_req_ready),
    .tx_req_idx(tx_req_idx), .tx_req_dlc(tx_req_dlc), .tx_done(tx_done), .tx_err(tx_err),
    .en_vec(en_vec), .txok_vec(txok_vec), .err_flag(err_flag), .tx_busy(tx_busy), .irq(irq)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic pulse_set(input logic [N-1:0] s, input logic [N-1:0] c);
    en_set_mask = s; en_clr_mask = c;
    @(negedge clk);
    en_set_mask = '0; en_clr_mask = '0;
  endtask

  task automatic pulse_ack(input logic [N-1:0] a, input bit e);
    drv_ack = a; err_ack = e;
    @(negedge clk);
    drv_ack = '0; err_ack = 1'b0;
  endtask

  task automatic push(input int idx, input bit err, input bit ack_same);
    exp_t e;
    e.idx = idx; e.err = err; e.ack_same = ack_same;
    q.push_back(e);
  endtask

  task automatic drain();
    do @(negedge clk);
    while (q.size() != 0 || tx_req_valid || tx_busy || mon_active);
  endtask

  // Monitor: transmitter model and scoreboard
  initial begin
    exp_t e;
    int first;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (tx_req_valid) begin
        mon_active = 1'b1;
        if (q.size() == 0) begin
          check(1'b0, "R5 unexpected offer", int'(tx_req_idx), -1);
          mon_ready = 1'b1; @(negedge clk); mon_ready = 1'b0;
          mon_done = 1'b1; @(negedge clk); mon_done = 1'b0;
        end else begin
          e = q.pop_front();
          check(int'(tx_req_idx) == e.idx, "R5 offer order", int'(tx_req_idx), e.idx);
          check(tx_req_dlc == dlc_cfg[e.idx], "R6 offered count", int'(tx_req_dlc),
                int'(dlc_cfg[e.idx]));
          first = int'(tx_req_idx);
          @(negedge clk);
          check(tx_req_valid && int'(tx_req_idx) == first, "R6 offer held",
                int'(tx_req_idx), first);
          mon_ready = 1'b1;
          @(negedge clk);
          mon_ready = 1'b0;
          check(tx_busy && !tx_req_valid, "R10 busy after accept", int'(tx_busy), 1);
          repeat (3) @(negedge clk);
          if (e.err) mon_err = 1'b1; else mon_done = 1'b1;
          if (e.ack_same) mon_ack[e.idx] = 1'b1;
          @(negedge clk);
          mon_done = 1'b0; mon_err = 1'b0; mon_ack = '0;
          check(!tx_busy, "R10 busy drops on result", int'(tx_busy), 0);
          if (!e.err) begin
            check(!en_vec[e.idx] && txok_vec[e.idx], "R7 success retires",
                  int'({en_vec[e.idx], txok_vec[e.idx]}), 1);
            if (e.ack_same)
              check(txok_vec[e.idx], "R9 set beats ack", int'(txok_vec[e.idx]), 1);
          end else begin
            check(en_vec[e.idx] && err_flag, "R8 error keeps enable",
                  int'({en_vec[e.idx], err_flag}), 3);
          end
        end
        mon_active = 1'b0;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  // Driver
  initial begin
    cfg_dir = '1;
    for (int i = 0; i < N; i++) dlc_cfg[i] = 4'(i);
    repeat (3) @(negedge clk);
    check(en_vec == 0 && txok_vec == 0 && !err_flag && !tx_req_valid && !tx_busy && !irq,
          "R12 reset state", int'({en_vec, txok_vec}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R2 with the bus busy
    pulse_set(8'h05, 8'h00);
    check(en_vec == 8'h05, "R1 multi-bit set", int'(en_vec), 8'h05);
    pulse_set(8'h10, 8'h00);
    check(en_vec == 8'h15, "R1 zeros keep", int'(en_vec), 8'h15);
    pulse_set(8'h00, 8'h04);
    check(en_vec == 8'h11, "R2 clear", int'(en_vec), 8'h11);
    pulse_set(8'h02, 8'h02);
    check(en_vec == 8'h11, "R2 clear wins", int'(en_vec), 8'h11);
    repeat (4) @(negedge clk);
    check(!tx_req_valid, "R4 no offer while bus busy", int'(tx_req_valid), 0);
    pulse_set(8'h00, 8'hFF);
    check(en_vec == 8'h00, "R2 clear all", int'(en_vec), 0);

    // R5 ascending order, R9 same-cycle ack on bit 7
    push(2, 0, 0); push(5, 0, 0); push(7, 0, 1);
    pulse_set(8'hA4, 8'h00);
    bus_idle = 1'b1;
    drain();
    check(txok_vec == 8'hA4 && en_vec == 0, "R7 all retired", int'(txok_vec), 8'hA4);
    check(irq, "R11 irq on txok", int'(irq), 1);
    pulse_ack(8'h04, 1'b0);
    check(txok_vec == 8'hA0, "R9 ack one bit", int'(txok_vec), 8'hA0);
    pulse_ack(8'hFF, 1'b0);
    check(txok_vec == 0 && !irq, "R11 irq clears", int'(irq), 0);

    // R3 eligibility
    bus_idle = 1'b0;
    cfg_dir[1] = 1'b0;
    dlc_cfg[3] = 4'd9;
    push(6, 0, 0);
    pulse_set(8'h4A, 8'h00);
    bus_idle = 1'b1;
    drain();
    repeat (3) @(negedge clk);
    check(en_vec == 8'h0A && !tx_req_valid, "R3 ineligible untouched", int'(en_vec), 8'h0A);
    check(txok_vec == 8'h40, "R3 only eligible sent", int'(txok_vec), 8'h40);
    bus_idle = 1'b0;
    pulse_set(8'h00, 8'hFF);
    pulse_ack(8'hFF, 1'b0);
    cfg_dir = '1;
    dlc_cfg[3] = 4'd3;

    // R8 retry yields to a lower object enabled meanwhile
    push(4, 1, 0); push(1, 0, 0); push(4, 0, 0);
    pulse_set(8'h10, 8'h00);
    bus_idle = 1'b1;
    do @(negedge clk); while (!tx_busy);
    pulse_set(8'h02, 8'h00);
    drain();
    check(txok_vec == 8'h12 && en_vec == 0, "R8 retry completes", int'(txok_vec), 8'h12);
    check(err_flag && irq, "R8 error flag sticky", int'(err_flag), 1);
    pulse_ack(8'h12, 1'b0);
    check(irq, "R11 irq from error flag", int'(irq), 1);
    pulse_ack(8'h00, 1'b1);
    check(!err_flag && !irq, "R9 error ack", int'(err_flag), 0);

    // R10 stray done ignored, R4 offer timing
    bus_idle = 1'b0;
    pulse_set(8'h09, 8'h00);
    drv_done = 1'b1; @(negedge clk); drv_done = 1'b0;
    check(en_vec == 8'h09 && txok_vec == 0, "R10 stray done ignored",
          int'({en_vec, txok_vec}), 16'h0900);
    push(0, 0, 0); push(3, 0, 0);
    bus_idle = 1'b1;
    @(negedge clk);
    check(tx_req_valid, "R4 offer one cycle after idle bus", int'(tx_req_valid), 1);
    drain();
    check(txok_vec == 8'h09, "R7 final", int'(txok_vec), 8'h09);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule